// File: doc/BRIEF.md
# Shadowed PWM Generator with Prescaler

A single-channel pulse-width generator that counts a slow reference tick (one tick per microsecond) through a power-of-two prescaler. A 16-bit counter runs from zero to the active period minus one. The output is high while the counter is below the active duty value.

Software writes the period, duty and prescale code into shadow registers through a simple write port. Those writes have no effect on the waveform until the control register is written. If the channel is running, that control write arms a transfer. The transfer happens at the end of the period already under way, so every period is produced wholly with old or wholly with new settings. Writing a control word with the enable bit clear lets the running period finish, and the output is then held low.

Top module: `pwm_shadow_gen`

## Requirements
- R1: During and after reset the output is low and every readable register (addresses 0 to 3) reads zero.
- R2: Register map: address 1 holds the period shadow, address 2 the duty shadow and address 3 the prescale code in bits [1:0]. Each reads back what was written. Address 0 reads bit 0 = channel running and bit 1 = update pending.
- R3: A write of zero to the period shadow is ignored. A control write with bit 0 set while the period shadow is zero leaves the channel idle.
- R4: From idle, a control write with bit 0 set loads the shadows at once and starts a period at count zero. With a nonzero duty, the output is high in the cycle after the write.
- R5: With prescale code k, period P and duty D < P, the output repeats every P·2^k ticks and is high for the first D·2^k ticks of each period.
- R6: A duty at or above the period gives a constant high output. A duty of zero gives a constant low output.
- R7: Shadow writes that are not followed by a control write do not change the waveform, and they do not set the pending bit.
- R8: A control write while running sets pending. The new settings take over exactly when the current period completes, and pending clears in that same cycle.
- R9: A control write with bit 0 clear while running lets the current period finish. After that the output stays low and bit 0 of address 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per reference tick (1 µs) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| pwm_o | output | 1 | Pulse-width output |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse with at least one idle cycle between ticks. They also assume that a period counter, once running, never holds a zero period, because zero period writes are rejected. The bench drives the tick from a free-running divide-by-four counter, so that spacing always holds. It issues every register write as a one-cycle strobe set up away from the clock edge. Control writes are never timed to land on the exact cycle a period ends; the bench waits for the pending bit to clear before it arms the next update.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PRESC  = 2'd3;
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_PEND_BIT = 1;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              running_i,
  input  logic              xfer_i,
  output logic [CNT_W-1:0]  shd_period_o,
  output logic [CNT_W-1:0]  shd_duty_o,
  output logic [PRE_W-1:0]  shd_presc_o,
  output logic              req_en_o,
  output logic              start_o,
  output logic              pending_o
);
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic [PRE_W-1:0] presc_q, presc_d;
  logic             pend_q, pend_d;
  logic             req_q, req_d;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  // Start from idle only when a usable period sits in the shadow
  assign start_o = ctrl_wr && wr_data_i[CTRL_RUN_BIT] && !running_i
                   && (period_q != '0);

  always_comb begin
    period_d = period_q;
    duty_d   = duty_q;
    presc_d  = presc_q;
    pend_d   = pend_q;
    req_d    = req_q;
    if (wr_en_i && (wr_addr_i == ADDR_PERIOD) && (wr_data_i != '0))
      period_d = wr_data_i;
    if (wr_en_i && (wr_addr_i == ADDR_DUTY))
      duty_d = wr_data_i;
    if (wr_en_i && (wr_addr_i == ADDR_PRESC))
      presc_d = wr_data_i[PRE_W-1:0];
    if (ctrl_wr && running_i) begin
      pend_d = 1'b1;
      req_d  = wr_data_i[CTRL_RUN_BIT];
    end else if (xfer_i) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= '0;
      presc_q  <= '0;
      pend_q   <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      duty_q   <= duty_d;
      presc_q  <= presc_d;
      pend_q   <= pend_d;
      req_q    <= req_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CTRL: begin
        rd_data_o[CTRL_RUN_BIT]  = running_i;
        rd_data_o[CTRL_PEND_BIT] = pend_q;
      end
      ADDR_PERIOD: rd_data_o = period_q;
      ADDR_DUTY:   rd_data_o = duty_q;
      default:     rd_data_o[PRE_W-1:0] = presc_q;
    endcase
  end

  assign shd_period_o = period_q;
  assign shd_duty_o   = duty_q;
  assign shd_presc_o  = presc_q;
  assign req_en_o     = req_q;
  assign pending_o    = pend_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 2,
  localparam int DIV_W = (1 << PRE_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] lim;
  logic             adv;

  // Terminal count 2^code - 1, computed as a mask of low ones
  assign lim      = ~({DIV_W{1'b1}} << code_i);
  assign adv      = run_i && tick_i;
  assign strobe_o = adv && (div_q == lim);

  always_comb begin
    div_d = div_q;
    if (clr_i)
      div_d = '0;
    else if (adv)
      div_d = (div_q == lim) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             pending_i,
  input  logic             req_en_i,
  input  logic [CNT_W-1:0] shd_period_i,
  input  logic [CNT_W-1:0] shd_duty_i,
  input  logic [PRE_W-1:0] shd_presc_i,
  output logic             running_o,
  output logic             xfer_o,
  output logic             strobe_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_period_o,
  output logic [CNT_W-1:0] act_duty_o,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             run_q, run_d;
  logic             strobe, last, period_end, xfer, load;

  pwm_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .run_i   (run_q),
    .clr_i   (load),
    .code_i  (pre_q),
    .strobe_o(strobe)
  );

  assign last       = (cnt_q == per_q - ONE);
  assign period_end = strobe && last;
  assign xfer       = period_end && pending_i;
  assign load       = start_i || (xfer && req_en_i);

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    pre_d  = pre_q;
    run_d  = run_q;
    if (load) begin
      per_d  = shd_period_i;
      duty_d = shd_duty_i;
      pre_d  = shd_presc_i;
      cnt_d  = '0;
      run_d  = 1'b1;
    end else if (xfer) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (strobe) begin
      cnt_d = last ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      pre_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      pre_q  <= pre_d;
      run_q  <= run_d;
    end
  end

  assign pwm_o        = run_q && (cnt_q < duty_q);
  assign running_o    = run_q;
  assign xfer_o       = xfer;
  assign strobe_o     = strobe;
  assign cnt_o        = cnt_q;
  assign act_period_o = per_q;
  assign act_duty_o   = duty_q;
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              pwm_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             running, pending, strobe, xfer, req_en, start;
  logic [CNT_W-1:0] cnt, act_period, act_duty;
  logic [CNT_W-1:0] shd_period, shd_duty;
  logic [PRE_W-1:0] shd_presc;

  // Assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_regfile #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .running_i   (running),
    .xfer_i      (xfer),
    .shd_period_o(shd_period),
    .shd_duty_o  (shd_duty),
    .shd_presc_o (shd_presc),
    .req_en_o    (req_en),
    .start_o     (start),
    .pending_o   (pending)
  );

  pwm_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick_i      (tick_i),
    .start_i     (start),
    .pending_i   (pending),
    .req_en_i    (req_en),
    .shd_period_i(shd_period),
    .shd_duty_i  (shd_duty),
    .shd_presc_i (shd_presc),
    .running_o   (running),
    .xfer_o      (xfer),
    .strobe_o    (strobe),
    .cnt_o       (cnt),
    .act_period_o(act_period),
    .act_duty_o  (act_duty),
    .pwm_o       (pwm_o)
  );
endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             pwm_o,
  input logic             running,
  input logic             pending,
  input logic             strobe,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_duty
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pwm_o);

  assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < act_period));

  assert_strobe_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> tick_i);

  assert_settings_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !strobe) |=> ($stable(cnt) && $stable(act_period) && $stable(act_duty) && running));

  assert_xfer_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> ($past(strobe) && ($past(cnt) == $past(act_period) - ONE)));

  assert_no_zero_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (act_period != '0));

  assert_full_duty_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (act_duty >= act_period)) |-> pwm_o);
endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .pwm_o     (pwm_o),
  .running   (running),
  .pending   (pending),
  .strobe    (strobe),
  .cnt       (cnt),
  .act_period(act_period),
  .act_duty  (act_duty)
);

// File: tb/pwm_shadow_gen_bench.sv
module pwm_shadow_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [15:0] wr_data_i = 16'd0;
  logic [1:0]  rd_addr_i = 2'd0;
  logic [15:0] rd_data_o;
  logic        pwm_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tdiv = 0;
  int last_rise = 0;
  int prev_rise = 0;
  logic pwm_prev = 1'b0;

  pwm_shadow_gen u_pwm_shadow_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .pwm_o    (pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference tick: one cycle high every TICK_DIV clocks, changed off the edge
  always @(posedge clk) begin
    #2;
    tdiv = (tdiv + 1) % TICK_DIV;
    tick_i = (tdiv == 0);
  end

  // Cycle counter and rising-edge recorder
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (pwm_o && !pwm_prev) begin
      prev_rise = last_rise;
      last_rise = cyc;
    end
    pwm_prev = pwm_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr_i = a;
    #1;
    d = int'(rd_data_o);
    rd_addr_i = 2'd0;
    #1;
  endtask

  task automatic wait_val(input logic v);
    do @(negedge clk); while (pwm_o !== v);
  endtask

  task automatic measure(output int per, output int hi);
    int t0, t1, t2;
    wait_val(1'b0);
    wait_val(1'b1); t0 = cyc;
    wait_val(1'b0); t1 = cyc;
    wait_val(1'b1); t2 = cyc;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic wait_no_pending();
    rd_addr_i = 2'd0;
    do @(negedge clk); while (rd_data_o[1]);
  endtask

  task automatic apply(input int p, input int d, input int k);
    wr(2'd1, 16'(p)); wr(2'd2, 16'(d)); wr(2'd3, 16'(k)); wr(2'd0, 16'd1);
    wait_no_pending();
  endtask

  task automatic t_reset();
    int v;
    check("R1 output in reset", int'(pwm_o), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register readback in reset", v, 0);
    end
  endtask

  task automatic t_refuse_zero_period();
    int v, highs;
    wr(2'd0, 16'd1);
    rd(2'd0, v);
    check("R3 enable refused with zero period", v, 0);
    highs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); highs += int'(pwm_o); end
    check("R3 output stays low after refused enable", highs, 0);
  endtask

  task automatic t_registers();
    int v;
    wr(2'd1, 16'd10); wr(2'd2, 16'd3); wr(2'd3, 16'd1);
    rd(2'd1, v); check("R2 period shadow readback", v, 10);
    rd(2'd2, v); check("R2 duty shadow readback", v, 3);
    rd(2'd3, v); check("R2 prescale readback", v, 1);
    wr(2'd1, 16'd0);
    rd(2'd1, v); check("R3 zero period write ignored", v, 10);
  endtask

  task automatic t_start();
    int v, per, hi;
    wr(2'd0, 16'd1);
    check("R4 output high right after enable", int'(pwm_o), 1);
    rd(2'd0, v); check("R4 running bit set", v, 1);
    measure(per, hi); measure(per, hi);
    check("R5 period P=10 k=1", per, 10*2*TICK_DIV);
    check("R5 high time D=3 k=1", hi, 3*2*TICK_DIV);
  endtask

  task automatic t_shadow_hold();
    int v, per, hi;
    wr(2'd1, 16'd4); wr(2'd2, 16'd1); wr(2'd3, 16'd0);
    rd(2'd0, v); check("R7 no pending without control write", v, 1);
    measure(per, hi);
    check("R7 period unchanged by shadow writes", per, 80);
    check("R7 high time unchanged by shadow writes", hi, 24);
  endtask

  task automatic t_update();
    int v, per, hi;
    wr(2'd0, 16'd1);
    rd(2'd0, v); check("R8 pending set by control write", v, 3);
    wait_no_pending();
    check("R8 new period starts at transfer", int'(pwm_o), 1);
    check("R8 old period completed before transfer", last_rise - prev_rise, 80);
    measure(per, hi);
    check("R8 new period after transfer", per, 4*TICK_DIV);
    check("R8 new high time after transfer", hi, 1*TICK_DIV);
  endtask

  task automatic t_prescale();
    int per, hi;
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      apply(5, 2, k);
      measure(per, hi);
      check("R5 period across prescale codes", per, 5*(1<<k)*TICK_DIV);
      check("R5 high time across prescale codes", hi, 2*(1<<k)*TICK_DIV);
    end
  endtask

  task automatic t_duty_limits();
    int lows, highs;
    apply(6, 6, 0);
    lows = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); lows += int'(!pwm_o); end
    check("R6 duty equal to period is constant high", lows, 0);
    apply(6, 9, 0);
    lows = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); lows += int'(!pwm_o); end
    check("R6 duty above period is constant high", lows, 0);
    apply(6, 0, 0);
    highs = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); highs += int'(pwm_o); end
    check("R6 zero duty is constant low", highs, 0);
  endtask

  task automatic t_disable();
    int v, highs;
    apply(10, 3, 0);
    wr(2'd0, 16'd0);
    rd(2'd0, v); check("R9 disable is pending while period runs", v, 3);
    wait_no_pending();
    check("R9 running period completed before stop", cyc - last_rise, 10*TICK_DIV);
    rd(2'd0, v); check("R9 running bit clear after stop", v, 0);
    highs = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); highs += int'(pwm_o); end
    check("R9 output held low after stop", highs, 0);
    wr(2'd0, 16'd1);
    check("R4 restart from idle is immediate", int'(pwm_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_refuse_zero_period();
    t_registers();
    t_start();
    t_shadow_hold();
    t_update();
    t_prescale();
    t_duty_limits();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WDOG, WDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule